// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block tracks the state of a single DRAM bank (idle, or active with one open row) and turns each incoming access into the shortest legal series of bank commands. A request carries a row, a column and a read/write direction. When accepted, it is classified against the bank state: a hit on the open row, a conflict with a different open row, or an access to an idle bank. The sequencer then walks through precharge, row activate and column access, each lasting a parameterised number of clock cycles. It raises a one-cycle completion pulse together with the classification.

A per-request policy input chooses between leaving the row open after the access and closing it at once. With the open policy, later accesses to the same row hit. With the close policy, the bank is precharged straight after the column phase, so the next access finds it idle. A single bus-turnaround cycle is placed before the column phase whenever the direction differs from that of the previous column access.

Top module: `dram_bank_seq`

## Requirements
- R1: A request to the open row of an active bank issues only a column strobe; done_o rises in the last cycle of the column phase, COL_CYC cycles after acceptance when no turnaround applies.
- R2: A request to a different row of an active bank issues precharge, then activate, then column, one strobe each in that order; done_o comes PRE_CYC+ACT_CYC+COL_CYC cycles after acceptance when no turnaround applies.
- R3: A request to an idle bank issues activate, then column, with no precharge; done_o comes ACT_CYC+COL_CYC cycles after acceptance when no turnaround applies.
- R4: A precharge leaves the bank idle, so the next request, even to the previous row, is classified as an idle-bank access.
- R5: With close_page_i low at acceptance, the row stays open after the access, and a following request to that row is a hit.
- R6: With close_page_i high at acceptance, a precharge strobe follows in the cycle after done_o, and busy_o stays high for PRE_CYC further cycles.
- R7: When the direction of a request differs from that of the previous column access, exactly one extra cycle is placed just before the column phase; the first access after reset gets none.
- R8: A request is taken only while busy_o is low; a request presented while busy_o is high has no effect on the commands or the bank state.
- R9: done_o is high for exactly one cycle per access. In that cycle, kind_o gives the class (0 = hit, 1 = row conflict, 2 = idle bank) and hit_o is high only for class 0.
- R10: After reset, busy_o, done_o and all strobes are low, and the bank is idle.
- R11: cmd_row_o holds the request row when act_o is high; cmd_col_o and cmd_we_o hold the request column and direction when col_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_row_i | input | ROW_W | Requested row |
| req_col_i | input | COL_W | Requested column |
| req_we_i | input | 1 | 1 = write, 0 = read |
| close_page_i | input | 1 | 1 = close the row after this access |
| busy_o | output | 1 | Sequencer occupied; requests ignored |
| pre_o | output | 1 | Precharge strobe |
| act_o | output | 1 | Row activate strobe |
| col_o | output | 1 | Column access strobe |
| cmd_row_o | output | ROW_W | Row address for the current access |
| cmd_col_o | output | COL_W | Column address for the current access |
| cmd_we_o | output | 1 | Direction for the current access |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Row-buffer hit, valid with done_o |
| kind_o | output | 2 | Access class, valid with done_o |

## Verification
The assertions assume that each phase duration is at least one cycle. They also assume that the request fields are stable in any cycle where req_valid_i is high. Together, these keep the strobe for a phase to a single cycle and keep the command address in step with the request that was taken. The stimulus changes inputs only on the falling clock edge and raises a request only after busy_o is seen low. The one exception is a deliberate stray request during an access, which targets the ignore rule.

// File: rtl/dram_bank_seq_pkg.sv
package dram_bank_seq_pkg;

  typedef enum logic [1:0] {
    KIND_HIT      = 2'd0,
    KIND_CONFLICT = 2'd1,
    KIND_IDLE     = 2'd2
  } acc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ACT  = 3'd2,
    ST_TURN = 3'd3,
    ST_COL  = 3'd4,
    ST_CPRE = 3'd5
  } seq_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
  parameter int unsigned ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_stb_i,
  input  logic             act_stb_i,
  input  logic             col_stb_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             we_i,
  output logic             open_o,
  output logic [ROW_W-1:0] open_row_o,
  output logic             prev_valid_o,
  output logic             last_we_o
);

  logic             open_q;
  logic [ROW_W-1:0] open_row_q;
  logic             prev_valid_q;
  logic             last_we_q;

  // precharge drops the row at its first cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q     <= 1'b0;
      open_row_q <= '0;
    end else if (pre_stb_i) begin
      open_q <= 1'b0;
    end else if (act_stb_i) begin
      open_q     <= 1'b1;
      open_row_q <= row_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_valid_q <= 1'b0;
      last_we_q    <= 1'b0;
    end else if (col_stb_i) begin
      prev_valid_q <= 1'b1;
      last_we_q    <= we_i;
    end
  end

  assign open_o       = open_q;
  assign open_row_o   = open_row_q;
  assign prev_valid_o = prev_valid_q;
  assign last_we_o    = last_we_q;

  a_r3_act_idle_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_stb_i |-> !open_q);

  a_r2_pre_active_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_stb_i |-> open_q);

  a_r4_pre_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_stb_i |=> !open_q);

endmodule

// File: rtl/bank_access_classifier.sv
module bank_access_classifier
  import dram_bank_seq_pkg::*;
#(
  parameter int unsigned ROW_W = 14
) (
  input  logic             open_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic             prev_valid_i,
  input  logic             last_we_i,
  input  logic             req_we_i,
  output acc_kind_e        kind_o,
  output logic             turn_o
);

  always_comb begin
    if (!open_i)                    kind_o = KIND_IDLE;
    else if (open_row_i == req_row_i) kind_o = KIND_HIT;
    else                            kind_o = KIND_CONFLICT;
  end

  assign turn_o = prev_valid_i && (last_we_i != req_we_i);

endmodule

// File: rtl/bank_phase_timer.sv
module bank_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_bank_seq_pkg::*;
#(
  parameter int unsigned ROW_W   = 14,
  parameter int unsigned COL_W   = 10,
  parameter int unsigned PRE_CYC = 3,
  parameter int unsigned ACT_CYC = 3,
  parameter int unsigned COL_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             req_we_i,
  input  logic             close_page_i,
  output logic             busy_o,
  output logic             pre_o,
  output logic             act_o,
  output logic             col_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic             cmd_we_o,
  output logic             done_o,
  output logic             hit_o,
  output logic [1:0]       kind_o
);

  localparam int unsigned MaxCyc = max3(PRE_CYC, ACT_CYC, COL_CYC);
  localparam int unsigned CntW   = (MaxCyc < 2) ? 1 : $clog2(MaxCyc);

  seq_state_e       state_q, state_d;
  logic [CntW-1:0]  cnt;
  logic             first, last;
  logic             accept;

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             we_q, close_q, turn_q;
  acc_kind_e        kind_q;

  logic             open, prev_valid, last_we, turn_now;
  logic [ROW_W-1:0] open_row;
  acc_kind_e        kind_now;

  bank_row_tracker #(.ROW_W(ROW_W)) i_tracker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pre_stb_i    (pre_o),
    .act_stb_i    (act_o),
    .col_stb_i    (col_o),
    .row_i        (row_q),
    .we_i         (we_q),
    .open_o       (open),
    .open_row_o   (open_row),
    .prev_valid_o (prev_valid),
    .last_we_o    (last_we)
  );

  bank_access_classifier #(.ROW_W(ROW_W)) i_classifier (
    .open_i       (open),
    .open_row_i   (open_row),
    .req_row_i    (req_row_i),
    .prev_valid_i (prev_valid),
    .last_we_i    (last_we),
    .req_we_i     (req_we_i),
    .kind_o       (kind_now),
    .turn_o       (turn_now)
  );

  bank_phase_timer #(.CNT_W(CntW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .cnt_o  (cnt)
  );

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign first  = (cnt == '0);

  always_comb begin
    unique case (state_q)
      ST_PRE, ST_CPRE: last = (cnt == CntW'(PRE_CYC - 1));
      ST_ACT:          last = (cnt == CntW'(ACT_CYC - 1));
      ST_COL:          last = (cnt == CntW'(COL_CYC - 1));
      default:         last = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        unique case (kind_now)
          KIND_HIT:      state_d = turn_now ? ST_TURN : ST_COL;
          KIND_CONFLICT: state_d = ST_PRE;
          default:       state_d = ST_ACT;
        endcase
      end
      ST_PRE:  if (last) state_d = ST_ACT;
      ST_ACT:  if (last) state_d = turn_q ? ST_TURN : ST_COL;
      ST_TURN: state_d = ST_COL;
      ST_COL:  if (last) state_d = close_q ? ST_CPRE : ST_IDLE;
      ST_CPRE: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      col_q   <= '0;
      we_q    <= 1'b0;
      close_q <= 1'b0;
      turn_q  <= 1'b0;
      kind_q  <= KIND_IDLE;
    end else if (accept) begin
      row_q   <= req_row_i;
      col_q   <= req_col_i;
      we_q    <= req_we_i;
      close_q <= close_page_i;
      turn_q  <= turn_now;
      kind_q  <= kind_now;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign pre_o     = ((state_q == ST_PRE) || (state_q == ST_CPRE)) && first;
  assign act_o     = (state_q == ST_ACT) && first;
  assign col_o     = (state_q == ST_COL) && first;
  assign done_o    = (state_q == ST_COL) && last;
  assign hit_o     = done_o && (kind_q == KIND_HIT);
  assign kind_o    = kind_q;
  assign cmd_row_o = row_q;
  assign cmd_col_o = col_q;
  assign cmd_we_o  = we_q;

  initial begin
    a_r1_phase_len: assert (PRE_CYC >= 1 && ACT_CYC >= 1 && COL_CYC >= 1);
  end

  a_r2_one_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pre_o, act_o, col_o}));

  a_r8_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);

  a_r8_busy_holds_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cmd_row_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_hit_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> done_o);

  a_r6_close_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && close_q) |=> (pre_o && busy_o));

  a_r5_open_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !close_q) |=> !busy_o);

endmodule

// File: tb/test_dram_bank_seq.sv
module test_dram_bank_seq;

  localparam int unsigned RW = 14;
  localparam int unsigned CW = 10;
  localparam int P = 3, A = 3, C = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic          req_we = 1'b0;
  logic          close_page = 1'b0;
  logic          busy, pre, act, col, cmd_we, done, hit;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;
  logic [1:0]    kind;

  int checks = 0, fails = 0;
  bit have_prev = 0, last_we = 0, finished = 0;

  always #5 clk = ~clk;

  dram_bank_seq #(.ROW_W(RW), .COL_W(CW), .PRE_CYC(P), .ACT_CYC(A), .COL_CYC(C)) i_dram_bank_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_row_i(req_row),
    .req_col_i(req_col), .req_we_i(req_we), .close_page_i(close_page),
    .busy_o(busy), .pre_o(pre), .act_o(act), .col_o(col), .cmd_row_o(cmd_row),
    .cmd_col_o(cmd_col), .cmd_we_o(cmd_we), .done_o(done), .hit_o(hit), .kind_o(kind)
  );

  task automatic check(input string req, input int act_v, input int exp_v, input string what);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  // one access; ek: 0 hit, 1 conflict, 2 idle
  task automatic access(input int row, input int cl, input bit wr, input bit cls,
                        input int ek, input bit intrude, input string req);
    int n, lat, pre_n, post_pre, act_n, col_n, col_at, done_n, done_at, tail, got_kind, got_hit;
    bit turn, seen;
    turn = have_prev && (last_we != wr);
    lat  = (ek == 1 ? P : 0) + (ek != 0 ? A : 0) + (turn ? 1 : 0) + C;
    pre_n = 0; post_pre = 0; act_n = 0; col_n = 0; col_at = 0;
    done_n = 0; done_at = 0; tail = 0; got_kind = -1; got_hit = -1; seen = 0;
    @(negedge clk);
    check(req, busy, 0, "busy before request");
    req_row = RW'(row); req_col = CW'(cl); req_we = wr; close_page = cls; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (n = 1; n < 60; n++) begin
      if (pre) begin
        if (seen) post_pre++; else pre_n++;
      end
      if (act) begin
        act_n++;
        check("R11", cmd_row, row, "row at activate");
      end
      if (col) begin
        col_n++; col_at = n;
        check("R11", cmd_col, cl, "column at column strobe");
        check("R11", cmd_we, wr, "direction at column strobe");
      end
      if (done) begin
        done_n++; done_at = n; seen = 1; got_kind = kind; got_hit = hit;
      end else if (seen && busy) tail++;
      if (intrude && n == 2) begin
        req_row = RW'(row + 7); req_we = ~wr; req_valid = 1'b1;
      end
      if (intrude && n == 3) req_valid = 1'b0;
      if (seen && !busy) break;
      @(negedge clk);
    end
    check(req, done_at, lat, "done latency");
    check("R9", done_n, 1, "done pulses");
    check("R9", got_kind, ek, "kind");
    check("R9", got_hit, (ek == 0) ? 1 : 0, "hit flag");
    check(req, pre_n, (ek == 1) ? 1 : 0, "precharge strobes");
    check(req, act_n, (ek != 0) ? 1 : 0, "activate strobes");
    check(req, col_n, 1, "column strobes");
    check("R7", col_at, lat - C + 1, "column strobe cycle");
    check("R6", post_pre, cls ? 1 : 0, "precharge after done");
    check("R6", tail, cls ? P : 0, "busy cycles after done");
    have_prev = 1; last_we = wr;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10", busy, 0, "busy after reset");
    check("R10", done, 0, "done after reset");
    check("R10", {pre, act, col}, 0, "strobes after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    access(5, 1, 0, 0, 2, 0, "R3");    // idle bank, first access: no turnaround
    access(5, 7, 0, 0, 0, 0, "R5");    // row stayed open: hit
    access(5, 8, 1, 0, 0, 0, "R7");    // read->write turnaround on hit
    access(9, 2, 1, 0, 1, 0, "R2");    // conflict
    access(9, 3, 0, 0, 0, 1, "R7");    // hit + turnaround, stray request while busy
    access(9, 4, 0, 0, 0, 0, "R8");    // stray ignored: row 9 still open
    access(9, 5, 0, 1, 0, 0, "R6");    // close-page hit
    access(9, 6, 1, 0, 2, 0, "R4");    // bank closed: idle, with turnaround
    access(3, 9, 0, 1, 1, 0, "R2");    // conflict + turnaround + close
    access(3, 1, 0, 0, 2, 0, "R4");
    access(3, 2, 0, 0, 0, 0, "R1");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule